// File: doc/BRIEF.md
# Fixed-Coefficient Two-State Kalman Filter Step

This block runs one Kalman filter iteration for a single candidate plant model. The model has two states and one scalar measurement. The model matrices (state transition, input gain and output row) are integer parameters fixed at elaboration. The block keeps its state estimate and its 2x2 covariance in registers between iterations. It accepts one sample at a time: a measured output together with the plant input applied at that step. For each sample it returns the innovation and the absolute value of the innovation. Downstream residual and model-selection logic uses these two values to score how well this model matches the plant.

Every product with a model constant is built from shifted copies of the operand and adders. The reciprocal of the innovation covariance is read from a table, scaled by 2^13. The products between variables use a pool of four multipliers. A fixed seven-phase schedule steers these multipliers through their operand select codes. All arithmetic is 32-bit two's complement and wraps modulo 2^32.

Samples enter on a valid/ready handshake. `in_ready` is high only while the block is idle and holds no unread result. Results leave on a second valid/ready handshake. While `out_ready` is low, the result stays on the outputs unchanged and no new sample is accepted. A one-cycle `init` pulse reloads the initial state and covariance and discards any iteration in progress.

Top module: `kf_step`

## Requirements
- R1: After reset, and in the cycle after an `init` pulse, the block is idle: `in_ready`=1 and `out_valid`=0. The state estimate and covariance hold their parameter initial values, so the first innovation is `in_meas - (H0*X0_0 + H1*X0_1)`.
- R2: The innovation is `in_meas - (H0*x0 + H1*x1)`, computed modulo 2^32, where x is the current state estimate. `out_abs` equals the innovation if it is non-negative and its negation otherwise.
- R3: An iteration occupies seven clock cycles, one phase per cycle, in this order: innovation, S and reciprocal, gain, state update, covariance update, state prediction, covariance prediction. `out_valid` is 0 after the sixth rising edge following the accepting edge and 1 after the seventh. `in_ready` stays 0 from the accepting edge until the result is taken. The multiplier select code is 4'b0001 in the gain phase, 4'b1100 in the state-update phase and 4'b1010 in the covariance-update phase.
- R4: While `out_valid`=1 and `out_ready`=0, `out_valid`, `out_innov` and `out_abs` hold their values and `in_ready` stays 0. The result is retired on the first rising edge where `out_ready`=1.
- R5: The gain is `K_i = R * (P*H^T)_i`, truncated to 32 bits. Here `S = H*P*H^T` and R comes from a 1024-entry table: R = 8192 when S <= 1, R = 8192/1023 = 8 when S > 1023, and R = floor(8192/S) otherwise.
- R6: The next state is `A*(x + ((K*innovation) >>> 13)) + B*u`, where u is `in_drive` and >>> is an arithmetic shift.
- R7: The next covariance is `A*(P - ((K_i*(H*P)_j) >>> 13))*A^T + B*B^T`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| init | input | 1 | Reload initial state and covariance, abort any iteration |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Block can accept a sample |
| in_meas | input | 32 | Measured plant output, signed |
| in_drive | input | 32 | Plant input for this step, signed |
| out_valid | output | 1 | Innovation result available |
| out_ready | input | 1 | Consumer takes the result |
| out_innov | output | 32 | Signed innovation |
| out_abs | output | 32 | Absolute value of the innovation |

## Verification
A sample is accepted on the rising edge where `in_valid` and `in_ready` are both high. The result becomes valid on the seventh rising edge after that. The bench samples on falling edges: it checks that `out_valid` is still low after the sixth edge, then checks validity, the innovation and its absolute value after the seventh. Gain, state update and covariance propagation are not visible at the ports. They are checked through the next iteration's innovation, which an integer model in the bench computes step by step. Stalls of several cycles hold `out_ready` low and confirm that the result and `in_ready` stay frozen until the result is taken.

// File: rtl/kf_pkg.sv
package kf_pkg;
  localparam int DW       = 32;
  localparam int SCALE_SH = 13;
  localparam int NPHASE   = 7;
  localparam int PHW      = 3;

  localparam logic [PHW-1:0] PH_IDLE = 3'd0;
  localparam logic [PHW-1:0] PH_INN  = 3'd1;
  localparam logic [PHW-1:0] PH_SINV = 3'd2;
  localparam logic [PHW-1:0] PH_GAIN = 3'd3;
  localparam logic [PHW-1:0] PH_XUPD = 3'd4;
  localparam logic [PHW-1:0] PH_PUPD = 3'd5;
  localparam logic [PHW-1:0] PH_XEST = 3'd6;
  localparam logic [PHW-1:0] PH_PEST = 3'd7;

  typedef logic signed [DW-1:0] word_t;

  typedef enum logic [3:0] {
    MS_IDLE = 4'b0000,
    MS_GAIN = 4'b0001,
    MS_XUPD = 4'b1100,
    MS_PUPD = 4'b1010
  } mul_sel_e;

  // Product with an elaboration-time constant: sum of shifted operands.
  function automatic word_t cmul(input word_t x, input int c);
    int    mag;
    word_t acc;
    mag = (c < 0) ? -c : c;
    acc = '0;
    for (int i = 0; i < DW - 1; i++) begin
      if (mag[i]) acc = acc + (x <<< i);
    end
    return (c < 0) ? -acc : acc;
  endfunction
endpackage

// File: rtl/kf_recip_lut.sv
module kf_recip_lut
  import kf_pkg::*;
#(
  parameter int AW = 10,
  parameter int SH = SCALE_SH
) (
  input  word_t s,
  output word_t r
);
  localparam int DEPTH = 1 << AW;

  word_t          rom [DEPTH];
  logic [AW-1:0]  addr;

  for (genvar g = 0; g < DEPTH; g++) begin : g_rom
    localparam int DEN = (g <= 1) ? 1 : g;
    assign rom[g] = word_t'((1 << SH) / DEN);
  end

  always_comb begin
    if (s <= 1)                         addr = AW'(1);
    else if (s > word_t'(DEPTH - 1))    addr = AW'(DEPTH - 1);
    else                                addr = s[AW-1:0];
  end

  assign r = rom[addr];
endmodule

// File: rtl/kf_mul_pool.sv
module kf_mul_pool
  import kf_pkg::*;
#(
  parameter int NS = 2
) (
  input  mul_sel_e sel,
  input  word_t    sinv,
  input  word_t    inn,
  input  word_t    pht  [NS],
  input  word_t    hp   [NS],
  input  word_t    kg   [NS],
  output word_t    prod [NS*NS]
);
  localparam int NM = NS * NS;

  for (genvar m = 0; m < NM; m++) begin : g_mul
    localparam int RI = m / NS;
    localparam int CJ = m % NS;
    word_t op_a, op_b;
    always_comb begin
      op_a = '0;
      op_b = '0;
      case (sel)
        MS_GAIN: if (m < NS) begin op_a = sinv;  op_b = pht[m % NS]; end
        MS_XUPD: if (m < NS) begin op_a = kg[m % NS]; op_b = inn; end
        MS_PUPD: begin op_a = kg[RI]; op_b = hp[CJ]; end
        default: ;
      endcase
    end
    assign prod[m] = op_a * op_b;
  end
endmodule

// File: rtl/kf_seq.sv
module kf_seq
  import kf_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           init,
  input  logic           start,
  input  logic           out_ready,
  output logic [PHW-1:0] ph,
  output logic           out_valid,
  output logic           in_ready,
  output mul_sel_e       sel
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph        <= PH_IDLE;
      out_valid <= 1'b0;
    end else if (init) begin
      ph        <= PH_IDLE;
      out_valid <= 1'b0;
    end else begin
      if (start)                ph <= PH_INN;
      else if (ph == PH_PEST) begin
        ph        <= PH_IDLE;
        out_valid <= 1'b1;
      end else if (ph != PH_IDLE) ph <= ph + 1'b1;
      if (out_valid && out_ready) out_valid <= 1'b0;
    end
  end

  assign in_ready = (ph == PH_IDLE) && !out_valid;

  always_comb begin
    case (ph)
      PH_GAIN: sel = MS_GAIN;
      PH_XUPD: sel = MS_XUPD;
      PH_PUPD: sel = MS_PUPD;
      default: sel = MS_IDLE;
    endcase
  end
endmodule

// File: rtl/kf_step.sv
module kf_step
  import kf_pkg::*;
#(
  parameter int A00 = 1, parameter int A01 = 1,
  parameter int A10 = 0, parameter int A11 = 1,
  parameter int B0  = 1, parameter int B1  = 2,
  parameter int H0  = 3, parameter int H1  = 1,
  parameter int X0_0 = 0, parameter int X0_1 = 0,
  parameter int P0_00 = 20, parameter int P0_01 = 0,
  parameter int P0_10 = 0,  parameter int P0_11 = 20,
  parameter int LUT_AW = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_meas,
  input  logic [31:0] in_drive,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [31:0] out_innov,
  output logic [31:0] out_abs
);
  localparam int NS = 2;
  localparam int NM = NS * NS;
  localparam int AM  [NS][NS] = '{'{A00, A01}, '{A10, A11}};
  localparam int BV  [NS]     = '{B0, B1};
  localparam int HV  [NS]     = '{H0, H1};
  localparam int XIV [NS]     = '{X0_0, X0_1};
  localparam int PIM [NS][NS] = '{'{P0_00, P0_01}, '{P0_10, P0_11}};

  logic [PHW-1:0] ph_q;
  mul_sel_e       mul_sel;
  logic           accept;

  word_t xe [NS], xu [NS], pht [NS], hp [NS], kg [NS];
  word_t pe [NS][NS], pu [NS][NS];
  word_t y_q, u_q, inn_q, sinv_q;
  word_t prod [NM];

  word_t inn_c, s_c, sinv_c;
  word_t pht_c [NS], hp_c [NS], xe_c [NS];
  word_t m_c [NS][NS], pe_c [NS][NS];

  assign accept = in_valid && in_ready && !init;

  kf_seq u_seq (
    .clk(clk), .rst_n(rst_n), .init(init), .start(accept),
    .out_ready(out_ready), .ph(ph_q), .out_valid(out_valid),
    .in_ready(in_ready), .sel(mul_sel)
  );

  kf_recip_lut #(.AW(LUT_AW), .SH(SCALE_SH)) u_lut (.s(s_c), .r(sinv_c));

  kf_mul_pool #(.NS(NS)) u_pool (
    .sel(mul_sel), .sinv(sinv_q), .inn(inn_q), .pht(pht), .hp(hp),
    .kg(kg), .prod(prod)
  );

  // Constant-coefficient products, all shift-and-add.
  always_comb begin
    inn_c = y_q - (cmul(xe[0], HV[0]) + cmul(xe[1], HV[1]));
    for (int i = 0; i < NS; i++) begin
      pht_c[i] = cmul(pe[i][0], HV[0]) + cmul(pe[i][1], HV[1]);
      hp_c[i]  = cmul(pe[0][i], HV[0]) + cmul(pe[1][i], HV[1]);
      xe_c[i]  = cmul(xu[0], AM[i][0]) + cmul(xu[1], AM[i][1]) + cmul(u_q, BV[i]);
    end
    s_c = cmul(pht_c[0], HV[0]) + cmul(pht_c[1], HV[1]);
    for (int i = 0; i < NS; i++)
      for (int j = 0; j < NS; j++)
        m_c[i][j] = cmul(pu[i][0], AM[j][0]) + cmul(pu[i][1], AM[j][1]);
    for (int i = 0; i < NS; i++)
      for (int j = 0; j < NS; j++)
        pe_c[i][j] = cmul(m_c[0][j], AM[i][0]) + cmul(m_c[1][j], AM[i][1])
                   + word_t'(BV[i] * BV[j]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y_q <= '0; u_q <= '0; inn_q <= '0; sinv_q <= '0;
      for (int i = 0; i < NS; i++) begin
        xe[i] <= word_t'(XIV[i]); xu[i] <= '0;
        pht[i] <= '0; hp[i] <= '0; kg[i] <= '0;
        for (int j = 0; j < NS; j++) begin
          pe[i][j] <= word_t'(PIM[i][j]); pu[i][j] <= '0;
        end
      end
    end else if (init) begin
      for (int i = 0; i < NS; i++) begin
        xe[i] <= word_t'(XIV[i]);
        for (int j = 0; j < NS; j++) pe[i][j] <= word_t'(PIM[i][j]);
      end
    end else begin
      if (accept) begin
        y_q <= word_t'(in_meas);
        u_q <= word_t'(in_drive);
      end
      case (ph_q)
        PH_INN:  inn_q <= inn_c;
        PH_SINV: begin
          sinv_q <= sinv_c;
          for (int i = 0; i < NS; i++) begin
            pht[i] <= pht_c[i];
            hp[i]  <= hp_c[i];
          end
        end
        PH_GAIN: for (int i = 0; i < NS; i++) kg[i] <= prod[i];
        PH_XUPD: for (int i = 0; i < NS; i++) xu[i] <= xe[i] + (prod[i] >>> SCALE_SH);
        PH_PUPD:
          for (int i = 0; i < NS; i++)
            for (int j = 0; j < NS; j++)
              pu[i][j] <= pe[i][j] - (prod[i*NS+j] >>> SCALE_SH);
        PH_XEST: for (int i = 0; i < NS; i++) xe[i] <= xe_c[i];
        PH_PEST:
          for (int i = 0; i < NS; i++)
            for (int j = 0; j < NS; j++) pe[i][j] <= pe_c[i][j];
        default: ;
      endcase
    end
  end

  assign out_innov = inn_q;
  assign out_abs   = (inn_q < 0) ? -inn_q : inn_q;
endmodule

// File: rtl/kf_step_chk.sv
module kf_step_chk
  import kf_pkg::*;
(
  input logic           clk,
  input logic           rst_n,
  input logic           init,
  input logic           in_ready,
  input logic           out_valid,
  input logic           out_ready,
  input logic [31:0]    out_innov,
  input logic [31:0]    out_abs,
  input logic [PHW-1:0] ph,
  input mul_sel_e       sel
);
  p_init_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> (in_ready && !out_valid));

  p_abs_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_abs == ($signed(out_innov) < 0 ? -out_innov : out_innov)));

  p_busy_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ph != PH_IDLE) |-> !in_ready);

  p_done_after_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> ($past(ph) == PH_PEST));

  p_gain_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_GAIN) |-> (sel == 4'b0001));

  p_xupd_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_XUPD) |-> (sel == 4'b1100));

  p_pupd_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_PUPD) |-> (sel == 4'b1010));

  p_hold_result_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !init) |=> (out_valid && $stable(out_innov) && !in_ready));
endmodule

bind kf_step kf_step_chk chk_i (
  .clk(clk), .rst_n(rst_n), .init(init), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_innov(out_innov),
  .out_abs(out_abs), .ph(ph_q), .sel(mul_sel)
);

// File: tb/kf_step_tb_top.sv
module kf_step_tb_top;
  localparam int TA00 = 1, TA01 = 1, TA10 = 0, TA11 = 1;
  localparam int TB0 = 1, TB1 = 2, TH0 = 3, TH1 = 1;
  localparam int TX0 = 5, TX1 = -2;
  localparam int TP00 = 20, TP01 = 0, TP10 = 0, TP11 = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic init = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [31:0] in_meas = '0;
  logic [31:0] in_drive = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [31:0] out_innov, out_abs;

  int total = 0;
  int bad = 0;
  int mx [2];
  int mp [2][2];
  int seed = 32'h1234_5678;

  always #5 clk = ~clk;

  kf_step #(
    .A00(TA00), .A01(TA01), .A10(TA10), .A11(TA11), .B0(TB0), .B1(TB1),
    .H0(TH0), .H1(TH1), .X0_0(TX0), .X0_1(TX1),
    .P0_00(TP00), .P0_01(TP01), .P0_10(TP10), .P0_11(TP11), .LUT_AW(10)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .init(init), .in_valid(in_valid),
    .in_ready(in_ready), .in_meas(in_meas), .in_drive(in_drive),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_innov(out_innov), .out_abs(out_abs)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_init();
    mx[0] = TX0; mx[1] = TX1;
    mp[0][0] = TP00; mp[0][1] = TP01; mp[1][0] = TP10; mp[1][1] = TP11;
  endtask

  function automatic int recip(input int s);
    if (s <= 1) return 8192;
    if (s > 1023) return 8192 / 1023;
    return 8192 / s;
  endfunction

  // Integer reference of one iteration (R2, R5, R6, R7).
  task automatic model_step(input int y, input int u, output int inn);
    int am [2][2];
    int bv [2];
    int hv [2];
    int pht [2], hp [2], kg [2], xu [2];
    int pu [2][2], mm [2][2];
    int s, r;
    am = '{'{TA00, TA01}, '{TA10, TA11}};
    bv = '{TB0, TB1};
    hv = '{TH0, TH1};
    inn = y - (hv[0]*mx[0] + hv[1]*mx[1]);
    for (int i = 0; i < 2; i++) begin
      pht[i] = mp[i][0]*hv[0] + mp[i][1]*hv[1];
      hp[i]  = mp[0][i]*hv[0] + mp[1][i]*hv[1];
    end
    s = hv[0]*pht[0] + hv[1]*pht[1];
    r = recip(s);
    for (int i = 0; i < 2; i++) kg[i] = r * pht[i];
    for (int i = 0; i < 2; i++) xu[i] = mx[i] + ((kg[i] * inn) >>> 13);
    for (int i = 0; i < 2; i++)
      for (int j = 0; j < 2; j++) pu[i][j] = mp[i][j] - ((kg[i] * hp[j]) >>> 13);
    for (int i = 0; i < 2; i++) mx[i] = am[i][0]*xu[0] + am[i][1]*xu[1] + bv[i]*u;
    for (int i = 0; i < 2; i++)
      for (int j = 0; j < 2; j++) mm[i][j] = pu[i][0]*am[j][0] + pu[i][1]*am[j][1];
    for (int i = 0; i < 2; i++)
      for (int j = 0; j < 2; j++)
        mp[i][j] = am[i][0]*mm[0][j] + am[i][1]*mm[1][j] + bv[i]*bv[j];
  endtask

  task automatic step(input int y, input int u, input int stall, input string tag);
    int ei, ea;
    model_step(y, u, ei);
    ea = (ei < 0) ? -ei : ei;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_meas = y; in_drive = u; out_ready = (stall == 0);
    @(posedge clk);
    #1 in_valid = 1'b0;
    repeat (6) @(posedge clk);
    @(negedge clk);
    check("R3 not valid after six edges", int'(out_valid), 0);
    check("R3 in_ready low while busy", int'(in_ready), 0);
    @(posedge clk);
    @(negedge clk);
    check("R3 valid after seven edges", int'(out_valid), 1);
    check({tag, " innovation"}, out_innov, ei);
    check("R2 absolute innovation", out_abs, ea);
    if (stall > 0) begin
      repeat (stall) @(negedge clk);
      check("R4 valid held under stall", int'(out_valid), 1);
      check("R4 innovation held", out_innov, ei);
      check("R4 abs held", out_abs, ea);
      check("R4 no accept while stalled", int'(in_ready), 0);
      out_ready = 1'b1;
      @(negedge clk);
      check("R4 retired after ready", int'(out_valid), 0);
    end
  endtask

  task automatic pulse_init();
    @(negedge clk);
    init = 1'b1;
    @(negedge clk);
    init = 1'b0;
    model_init();
    check("R1 in_ready after init", int'(in_ready), 1);
    check("R1 out_valid after init", int'(out_valid), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int y, u;
    model_init();
    repeat (3) @(negedge clk);
    check("R1 in_ready in reset", int'(in_ready), 1);
    check("R1 out_valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", int'(in_ready), 1);
    for (int run = 0; run < 3; run++) begin
      if (run > 0) pulse_init();
      for (int n = 0; n < 40; n++) begin
        seed = seed * 1103515245 + 12345;
        case (run)
          0: begin y = (seed >>> 20); u = (seed & 15) - 8; end
          1: begin y = (seed & 255) - 128; u = (seed >>> 28); end
          default: begin y = seed; u = seed >>> 4; end
        endcase
        if (n == 1) y = 0;
        if (n == 2) y = -1;
        if (n == 3) y = 32'h7fff_ffff;
        if (n == 4) y = 32'h8000_0000;
        step(y, u, (n % 7 == 3) ? (n % 5) + 2 : 0,
             (n == 0) ? "R1 first after load R2" : "R2 R5 R6 R7 tracked");
      end
    end
    // init while an iteration is in flight discards it (R1).
    @(negedge clk);
    in_valid = 1'b1; in_meas = 32'd77; in_drive = 32'd1;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    pulse_init();
    repeat (8) @(negedge clk);
    check("R1 aborted iteration gives no result", int'(out_valid), 0);
    step(100, 3, 0, "R1 first after abort R2");
    step(-50, -1, 3, "R2 R5 R6 R7 after abort");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule